// File: doc/BRIEF.md
# Polled Fixed-Latency Line Store

This block is a synthesizable backing store of four-word lines. It finishes a word write, a line write, a word read or a line read only after a set number of cycles. A requester does not get a completion event. Instead it presents the same request on every cycle it wants service. On each of those cycles the block gives one status code, and the code says whether the access has finished on that cycle.

Only one requester may hold the store at a time. Requesters are told apart by an identifier. The first one to arrive while the store is free takes it, and every other identifier is turned away with a wait code until the holder's access finishes. The latency is taken from a configuration input at the moment an access begins. The store never changes on a cycle that reports waiting. A separate, purely combinational viewing port returns any whole line for inspection.

Top module: `polled_mem`

## Requirements
- R1: After reset every word of every line reads as zero on the view port, and no requester holds the store.
- R2: An access starts on the first cycle a requester presents it while it may hold the store, and `lat_cfg` is sampled on that cycle as D. The access is answered WAIT on its first D presentations and OK on presentation D+1. With D = 0 it is answered OK at once. Later changes of `lat_cfg` do not affect an access already started.
- R3: The storage never changes on a cycle answered WAIT. A write changes the storage at the end of its OK cycle, and the view port shows the new value from the next cycle.
- R4: `req_op` selects the access: 0 word write, 1 line write, 2 word read, 3 line read. The line index is `req_addr[ADDR_W-1:2]` and the word offset is `req_addr[1:0]`. Word k of a line sits in bits [32k+31:32k]. A word write replaces only the addressed word. A line write replaces all four words and ignores the offset. On its OK cycle a word read returns the word on `resp_rword` and a line read returns the line on `resp_rline`. Both data outputs are zero on every other cycle.
- R5: While one identifier holds the store, a request from any other identifier is answered WAIT. Such a request neither advances nor ends the holder's count, and it does not touch the storage.
- R6: The store is released on the OK cycle. The next requester then serves its own full count of D WAIT answers.
- R7: If the holder presents a different address or a different operation while its access is pending, the count restarts from zero as a new access, and `lat_cfg` is sampled again.
- R8: `resp_code` is 2'b00 for OK, 2'b01 for WAIT and 2'b10 for BLOCKED. BLOCKED is never produced. A cycle with `req_valid` low is answered WAIT and has no effect.
- R9: `view_line` shows the line at `view_idx` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented on this cycle |
| req_id | input | ID_W | Identifier of the requester |
| req_op | input | 2 | Operation: 0 word write, 1 line write, 2 word read, 3 line read |
| req_addr | input | ADDR_W | Word address (line index and word offset) |
| req_wword | input | 32 | Data for a word write |
| req_wline | input | 128 | Data for a line write |
| lat_cfg | input | LAT_W | Latency D, sampled when an access starts |
| resp_code | output | 2 | Status of this cycle's request |
| resp_rword | output | 32 | Word read data, valid on the OK cycle |
| resp_rline | output | 128 | Line read data, valid on the OK cycle |
| view_idx | input | IDX_W | Line selected for viewing |
| view_line | output | 128 | Contents of the selected line |

## Verification
The status code and the read data are combinational answers to the presentation in the same cycle. The bench therefore drives each presentation just after a falling edge and compares the result one time unit later, still before the rising edge that would act on it. A write is due on the view port in the cycle after its OK, so the view is compared on every cycle against a behavioural memory. That memory is updated only at the rising edge of an OK presentation. Each access also has its presentations counted up to OK, and that count is checked against D+1, with the holding identifier and the restart rules applied.

// File: rtl/polled_mem_pkg.sv
package polled_mem_pkg;

  localparam int WORD_W = 32;
  localparam int WORDS_PER_LINE = 4;
  localparam int LINE_W = WORD_W * WORDS_PER_LINE;
  localparam int OFF_W = $clog2(WORDS_PER_LINE);

  typedef enum logic [1:0] {
    RSP_OK      = 2'b00,
    RSP_WAIT    = 2'b01,
    RSP_BLOCKED = 2'b10
  } resp_e;

  typedef enum logic [1:0] {
    OP_WR_WORD = 2'd0,
    OP_WR_LINE = 2'd1,
    OP_RD_WORD = 2'd2,
    OP_RD_LINE = 2'd3
  } op_e;

  function automatic logic op_writes(input logic [1:0] op);
    return (op == OP_WR_WORD) || (op == OP_WR_LINE);
  endfunction

  function automatic logic op_whole_line(input logic [1:0] op);
    return (op == OP_WR_LINE) || (op == OP_RD_LINE);
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off);
    return line[off*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] res;
    res = line;
    res[off*WORD_W +: WORD_W] = w;
    return res;
  endfunction

  function automatic resp_e status_of(input logic valid, input logic done);
    return (valid && done) ? RSP_OK : RSP_WAIT;
  endfunction

endpackage

// File: rtl/mem_owner_arb.sv
module mem_owner_arb
  import polled_mem_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 6,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic              grant,
  output logic              ev_foreign,
  output logic              ev_fresh,
  output logic              own_busy
);

  logic              busy_q;
  logic [ID_W-1:0]   id_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LAT_W-1:0]  lat_q;
  logic [LAT_W-1:0]  seen_q;
  logic [LAT_W-1:0]  lat_eff;
  logic [LAT_W-1:0]  seen_eff;
  logic              hold;

  always_comb begin
    ev_foreign = busy_q && (req_id != id_q);
    ev_fresh   = !busy_q || (!ev_foreign && ((req_op != op_q) || (req_addr != addr_q)));
    lat_eff    = ev_fresh ? lat_cfg : lat_q;
    seen_eff   = ev_fresh ? '0 : seen_q;
    grant      = req_valid && !ev_foreign && (seen_eff >= lat_eff);
    hold       = req_valid && !ev_foreign && !grant;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      id_q   <= '0;
      op_q   <= '0;
      addr_q <= '0;
      lat_q  <= '0;
      seen_q <= '0;
    end else if (grant) begin
      busy_q <= 1'b0;
      seen_q <= '0;
    end else if (hold) begin
      busy_q <= 1'b1;
      id_q   <= req_id;
      op_q   <= req_op;
      addr_q <= req_addr;
      lat_q  <= lat_eff;
      seen_q <= seen_eff + 1'b1;
    end
  end

  assign own_busy = busy_q;

endmodule

// File: rtl/mem_line_store.sv
module mem_line_store
  import polled_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_word,
  input  logic              we_line,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] acc_line,
  input  logic [IDX_W-1:0]  view_idx,
  output logic [LINE_W-1:0] view_line
);

  logic [LINE_W-1:0] lines_q [DEPTH];

  assign acc_line  = lines_q[acc_idx];
  assign view_line = lines_q[view_idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lines_q[g] <= '0;
        end else if (acc_idx == IDX_W'(g)) begin
          if (we_line)
            lines_q[g] <= wr_line;
          else if (we_word)
            lines_q[g] <= merge_word(lines_q[g], acc_off, wr_word);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/polled_mem.sv
module polled_mem
  import polled_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 3,
  parameter int LAT_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wword,
  input  logic [127:0]      req_wline,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic [1:0]        resp_code,
  output logic [31:0]       resp_rword,
  output logic [127:0]      resp_rline,
  input  logic [IDX_W-1:0]  view_idx,
  output logic [127:0]      view_line
);

  logic              grant;
  logic              ev_foreign;
  logic              ev_fresh;
  logic              own_busy;
  logic              ev_commit;
  logic              ev_read_done;
  logic [LINE_W-1:0] acc_line;
  logic [IDX_W-1:0]  acc_idx;
  logic [OFF_W-1:0]  acc_off;

  assign acc_idx = req_addr[ADDR_W-1:2];
  assign acc_off = req_addr[1:0];

  mem_owner_arb #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_id     (req_id),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .lat_cfg    (lat_cfg),
    .grant      (grant),
    .ev_foreign (ev_foreign),
    .ev_fresh   (ev_fresh),
    .own_busy   (own_busy)
  );

  assign ev_commit    = grant && op_writes(req_op);
  assign ev_read_done = grant && !op_writes(req_op);

  mem_line_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_word   (ev_commit && !op_whole_line(req_op)),
    .we_line   (ev_commit && op_whole_line(req_op)),
    .acc_idx   (acc_idx),
    .acc_off   (acc_off),
    .wr_word   (req_wword),
    .wr_line   (req_wline),
    .acc_line  (acc_line),
    .view_idx  (view_idx),
    .view_line (view_line)
  );

  always_comb begin
    resp_code  = status_of(req_valid, grant);
    resp_rword = '0;
    resp_rline = '0;
    if (ev_read_done) begin
      if (op_whole_line(req_op))
        resp_rline = acc_line;
      else
        resp_rword = pick_word(acc_line, acc_off);
    end
  end

endmodule

// File: rtl/polled_mem_chk.sv
module polled_mem_chk #(
  parameter int IDX_W = 4,
  parameter int LAT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       resp_code,
  input logic [LAT_W-1:0] lat_cfg,
  input logic [IDX_W-1:0] view_idx,
  input logic [127:0]     view_line,
  input logic             ev_foreign,
  input logic             ev_fresh,
  input logic             own_busy
);

  AST_WAIT_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_code == 2'b01) |=> ($stable(view_idx) -> $stable(view_line))); // R3

  AST_FOREIGN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_foreign) |-> resp_code == 2'b01); // R5

  AST_FOREIGN_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_foreign) |=> own_busy); // R5

  AST_OK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_code == 2'b00) |=> !own_busy); // R6

  AST_ZERO_LAT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_fresh && !ev_foreign && lat_cfg == '0) |-> resp_code == 2'b00); // R2

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> resp_code == 2'b01); // R8

  AST_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_code != 2'b10); // R8

endmodule

bind polled_mem polled_mem_chk #(.IDX_W(IDX_W), .LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .resp_code  (resp_code),
  .lat_cfg    (lat_cfg),
  .view_idx   (view_idx),
  .view_line  (view_line),
  .ev_foreign (ev_foreign),
  .ev_fresh   (ev_fresh),
  .own_busy   (own_busy)
);

// File: tb/sim_polled_mem.sv
module sim_polled_mem;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int ID_W = 3;
  localparam int LAT_W = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wword = '0;
  logic [127:0]      req_wline = '0;
  logic [LAT_W-1:0]  lat_cfg = '0;
  logic [1:0]        resp_code;
  logic [31:0]       resp_rword;
  logic [127:0]      resp_rline;
  logic [IDX_W-1:0]  view_idx = '0;
  logic [127:0]      view_line;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference: word array plus holder bookkeeping
  logic [31:0] ref_mem [DEPTH*4];
  bit ref_busy = 0;
  int ref_id, ref_op, ref_addr, ref_presented, ref_lat;

  polled_mem #(.DEPTH(DEPTH), .ID_W(ID_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_op(req_op), .req_addr(req_addr), .req_wword(req_wword),
    .req_wline(req_wline), .lat_cfg(lat_cfg), .resp_code(resp_code),
    .resp_rword(resp_rword), .resp_rline(resp_rline),
    .view_idx(view_idx), .view_line(view_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] ref_line(int idx);
    return {ref_mem[idx*4+3], ref_mem[idx*4+2], ref_mem[idx*4+1], ref_mem[idx*4]};
  endfunction

  task automatic check(bit good, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one presentation, entered just after a falling edge; returns 1 when OK was expected
  task automatic present(bit v, int id, int op, int addr, logic [31:0] w,
                         logic [127:0] l, int lat, string tag, output bit ok);
    bit other, again;
    int count, need;
    logic [1:0] e_code;
    logic [31:0] e_word;
    logic [127:0] e_line;
    req_valid = v; req_id = ID_W'(id); req_op = 2'(op); req_addr = ADDR_W'(addr);
    req_wword = w; req_wline = l; lat_cfg = LAT_W'(lat); view_idx = IDX_W'(addr / 4);
    #1;
    other = ref_busy && (id != ref_id);
    again = ref_busy && !other && (op == ref_op) && (addr == ref_addr);
    count = again ? ref_presented : 0;
    need  = again ? ref_lat : lat;
    ok = v && !other && (count == need);
    e_code = ok ? 2'b00 : 2'b01;
    e_word = (ok && op == 2) ? ref_mem[addr] : 32'h0;
    e_line = (ok && op == 3) ? ref_line(addr / 4) : 128'h0;
    check(resp_code == e_code, tag, "resp_code", 128'(resp_code), 128'(e_code));
    check(resp_rword == e_word, "R4", "resp_rword", 128'(resp_rword), 128'(e_word));
    check(resp_rline == e_line, "R4", "resp_rline", resp_rline, e_line);
    check(view_line == ref_line(addr / 4), "R9", "view_line", view_line, ref_line(addr / 4));
    @(posedge clk);
    if (ok) begin
      if (op == 0) ref_mem[addr] = w;
      if (op == 1) for (int k = 0; k < 4; k++) ref_mem[(addr / 4) * 4 + k] = l[k*32 +: 32];
      ref_busy = 0;
    end else if (v && !other) begin
      ref_busy = 1; ref_id = id; ref_op = op; ref_addr = addr;
      ref_presented = count + 1; ref_lat = need;
    end
    @(negedge clk);
  endtask

  // repeat one request until OK, checking how many presentations it took
  task automatic until_ok(int id, int op, int addr, logic [31:0] w, logic [127:0] l,
                          int lat, int exp_n, string tag);
    bit ok = 0;
    int n = 0;
    while (!ok && n < 40) begin
      present(1, id, op, addr, w, l, lat, tag, ok);
      n++;
    end
    check(n == exp_n, tag, "presentations to OK", 128'(n), 128'(exp_n));
  endtask

  initial begin : watchdog
    while (!finished && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    bit ok;
    int n;
    for (int i = 0; i < DEPTH*4; i++) ref_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared after reset, idle answer is WAIT (R8)
    for (int i = 0; i < DEPTH; i++) begin
      view_idx = IDX_W'(i);
      #1;
      check(view_line == 128'h0, "R1", "line after reset", view_line, 128'h0);
    end
    present(0, 0, 0, 0, 0, 0, 2, "R8", ok);

    // R2/R3: word write with D=2, view must stay unchanged during WAITs
    until_ok(1, 0, 5, 32'h11223344, 0, 2, 3, "R2");

    // R5/R6: holder 1 does a line write with D=3 while requester 2 keeps polling
    n = 0;
    ok = 0;
    while (!ok && n < 20) begin
      present(1, 1, 1, 8, 0, {32'hD3, 32'hC2, 32'hB1, 32'hA0}, 3, "R5", ok);
      n++;
      if (!ok) begin
        bit dummy;
        present(1, 2, 2, 5, 0, 0, 3, "R5", dummy);
      end
    end
    check(n == 4, "R5", "holder presentations", 128'(n), 128'd4);
    // R6: requester 2 now serves its own full count and reads the earlier word
    until_ok(2, 2, 5, 0, 0, 3, 4, "R6");

    // R2: zero latency completes at once
    until_ok(3, 0, 14, 32'hCAFE0001, 0, 0, 1, "R2");

    // R7: holder changes address mid-wait, count restarts
    present(1, 1, 0, 20, 32'h55, 0, 2, "R7", ok);
    present(0, 1, 0, 20, 32'h55, 0, 2, "R8", ok);
    until_ok(1, 0, 21, 32'h66, 0, 2, 3, "R7");
    // R7: change of operation on the same address also restarts
    present(1, 1, 2, 21, 0, 0, 1, "R7", ok);
    until_ok(1, 3, 21, 0, 0, 1, 2, "R7");

    // R2: latency sampled at start, later lat_cfg changes ignored
    present(1, 2, 3, 8, 0, 0, 4, "R2", ok);
    until_ok(2, 3, 8, 0, 0, 0, 4, "R2");

    // R4: word write into a line leaves neighbours, unwritten read gives zero
    until_ok(4, 0, 10, 32'hBEEF, 0, 1, 2, "R4");
    until_ok(4, 3, 8, 0, 0, 1, 2, "R4");
    until_ok(5, 2, 60, 0, 0, 2, 3, "R4");

    // final sweep of every line
    req_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      view_idx = IDX_W'(i);
      #1;
      check(view_line == ref_line(i), "R3", "final line", view_line, ref_line(i));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule